// File: doc/BRIEF.md
# Multi-Bank Clock Divider

This block takes one fast source clock and derives three output banks of four outputs each, plus a single feedback output. Each bank divides the source by its own ratio. A 2-bit select picks that ratio from a small set that differs from bank to bank, and the feedback output uses a 3-bit select. A shared pre-scale control either leaves every ratio as coded or doubles it. All ratios are even, so every output has an exact 50% duty cycle.

The block is held in reset to configure it. While the active-high synchronous reset is asserted, all outputs are held low, every divider counter is cleared, and the select inputs are captured. When reset is released, every divider starts on the same source edge, so all outputs rise together. Select changes made while the block runs have no effect until the next reset, so no output ever produces a shortened period. A phase control sets the upper two outputs of bank C either in phase with the lower two or inverted from them.

Top module: `clkdiv_banks`

## Requirements
- R1: While `rst` is high, all outputs (`q_a`, `q_b`, `q_c`, `q_fb`) read 0 from the cycle after the first clock edge that samples reset, including the inverted bank C outputs.
- R2: Bank A half-ratio codes: with `pre_half`=0, `sel_a` 00/01/10/11 divide the source by 4/6/8/12.
- R3: Bank B: with `pre_half`=0, `sel_b` 00/01/10/11 divide by 4/6/8/10.
- R4: Bank C: with `pre_half`=0, `sel_c` 00/01/10/11 divide by 2/4/6/8.
- R5: Feedback: with `pre_half`=0, `sel_fb` 000..111 divide by 4, 6, 8, 10, 8, 12, 16, 20.
- R6: With `pre_half`=1, every ratio in R2 to R5 is doubled.
- R7: Each output of ratio N is high for N/2 source cycles and then low for N/2 source cycles, repeating.
- R8: In the first cycle after the edge that samples `rst` low, every non-inverted output is high, so the rising edges of all banks are aligned.
- R9: With `c_inphase`=0, `q_c[3:2]` are the inverse of `q_c[1:0]` while running; with `c_inphase`=1, all four bank C outputs are equal. All outputs within bank A, bank B and the lower half of bank C are equal.
- R10: Changes on `pre_half`, `sel_a`, `sel_b`, `sel_c` or `sel_fb` while `rst` is low have no effect on the outputs; the values present during the last reset cycle apply.
- R11: Asserting `rst` for one cycle during operation restarts all dividers, with the selects present at that time, aligned as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset and output disable; captures the selects |
| pre_half | input | 1 | 1 doubles every division ratio |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| c_inphase | input | 1 | 1: bank C all in phase; 0: upper half of bank C inverted |
| q_a | output | 4 | Bank A outputs |
| q_b | output | 4 | Bank B outputs |
| q_c | output | 4 | Bank C outputs |
| q_fb | output | 1 | Feedback output |

## Verification
The bench follows every output cycle by cycle after release across ratio codes with the pre-scale both off and on. This exposes a wrong entry in a ratio table, a missing doubling, or an off-by-one in the half-period compare, which would show up as a stretched or shortened high phase. The smallest ratio, bank C code 00 with divide-by-2, is included because a counter that wraps one cycle late there would produce a divide-by-4. Selects are changed mid-run to catch a design that samples them live and truncates a period, and reset is pulsed for a single cycle to catch a divider that does not restart aligned. The inverted bank C outputs are checked during reset, where leaking the inversion would drive them high.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Width of a half-period count; largest half period is 20 source cycles.
    localparam int HALF_W = 5;

    typedef enum logic [1:0] {
        BANK_A  = 2'd0,
        BANK_B  = 2'd1,
        BANK_C  = 2'd2,
        BANK_FB = 2'd3
    } bank_e;

    // Raw select inputs as seen at the block edge.
    typedef struct packed {
        logic       pre_half;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic [1:0] sel_c;
        logic [2:0] sel_fb;
    } sel_t;

    // Captured half-period counts, one per divider.
    typedef struct packed {
        logic [HALF_W-1:0] half_a;
        logic [HALF_W-1:0] half_b;
        logic [HALF_W-1:0] half_c;
        logic [HALF_W-1:0] half_fb;
    } cfg_t;

    // Half of the division ratio for one divider, including the pre-scale.
    function automatic logic [HALF_W-1:0] half_count(bank_e bank, logic [2:0] code, logic pre);
        logic [HALF_W-1:0] base;
        base = '0;
        case (bank)
            BANK_A: begin
                case (code[1:0])
                    2'b00:   base = HALF_W'(2);
                    2'b01:   base = HALF_W'(3);
                    2'b10:   base = HALF_W'(4);
                    default: base = HALF_W'(6);
                endcase
            end
            BANK_B: begin
                case (code[1:0])
                    2'b00:   base = HALF_W'(2);
                    2'b01:   base = HALF_W'(3);
                    2'b10:   base = HALF_W'(4);
                    default: base = HALF_W'(5);
                endcase
            end
            BANK_C: begin
                base = HALF_W'(code[1:0]) + HALF_W'(1);
            end
            default: begin
                case (code)
                    3'b000:  base = HALF_W'(2);
                    3'b001:  base = HALF_W'(3);
                    3'b010:  base = HALF_W'(4);
                    3'b011:  base = HALF_W'(5);
                    3'b100:  base = HALF_W'(4);
                    3'b101:  base = HALF_W'(6);
                    3'b110:  base = HALF_W'(8);
                    default: base = HALF_W'(10);
                endcase
            end
        endcase
        return pre ? HALF_W'(base << 1) : base;
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel,
    output cfg_t cfg
);

    cfg_t cfg_next;

    always_comb begin
        cfg_next.half_a  = half_count(BANK_A,  {1'b0, sel.sel_a}, sel.pre_half);
        cfg_next.half_b  = half_count(BANK_B,  {1'b0, sel.sel_b}, sel.pre_half);
        cfg_next.half_c  = half_count(BANK_C,  {1'b0, sel.sel_c}, sel.pre_half);
        cfg_next.half_fb = half_count(BANK_FB, sel.sel_fb,        sel.pre_half);
    end

    // Selects are captured only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_next;
        end
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half,
    output logic              active,
    output logic              clk_out
);

    logic [HALF_W-1:0] cnt;
    logic              phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            phase  <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
        end else if (cnt == half - HALF_W'(1)) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    assign clk_out = active & ~phase;

endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
    parameter int BANK_W    = 4,
    parameter bit INV_UPPER = 1'b0
) (
    input  logic              active,
    input  logic              raw,
    input  logic              inphase,
    output logic [BANK_W-1:0] q
);

    localparam int LOW_W = BANK_W / 2;

    for (genvar i = 0; i < BANK_W; i++) begin : g_out
        if (INV_UPPER && i >= LOW_W) begin : g_inv
            assign q[i] = active & (raw ^ ~inphase);
        end else begin : g_pass
            assign q[i] = raw;
        end
    end

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
    import clkdiv_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int CNT_W  = HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_half,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [1:0]        sel_c,
    input  logic [2:0]        sel_fb,
    input  logic              c_inphase,
    output logic [BANK_W-1:0] q_a,
    output logic [BANK_W-1:0] q_b,
    output logic [BANK_W-1:0] q_c,
    output logic              q_fb
);

    localparam int NDIV = 4;

    sel_t sel_in;
    cfg_t cfg_q;

    logic [CNT_W-1:0] half_v [NDIV];
    logic [NDIV-1:0]  act_v;
    logic [NDIV-1:0]  raw_v;

    assign sel_in.pre_half = pre_half;
    assign sel_in.sel_a    = sel_a;
    assign sel_in.sel_b    = sel_b;
    assign sel_in.sel_c    = sel_c;
    assign sel_in.sel_fb   = sel_fb;

    clkdiv_cfg u_cfg (
        .clk (clk),
        .rst (rst),
        .sel (sel_in),
        .cfg (cfg_q)
    );

    assign half_v[BANK_A]  = CNT_W'(cfg_q.half_a);
    assign half_v[BANK_B]  = CNT_W'(cfg_q.half_b);
    assign half_v[BANK_C]  = CNT_W'(cfg_q.half_c);
    assign half_v[BANK_FB] = CNT_W'(cfg_q.half_fb);

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        clkdiv_counter #(.HALF_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .half    (half_v[d]),
            .active  (act_v[d]),
            .clk_out (raw_v[d])
        );
    end

    clkdiv_fanout #(.BANK_W(BANK_W), .INV_UPPER(1'b0)) u_fan_a (
        .active  (act_v[BANK_A]),
        .raw     (raw_v[BANK_A]),
        .inphase (1'b1),
        .q       (q_a)
    );

    clkdiv_fanout #(.BANK_W(BANK_W), .INV_UPPER(1'b0)) u_fan_b (
        .active  (act_v[BANK_B]),
        .raw     (raw_v[BANK_B]),
        .inphase (1'b1),
        .q       (q_b)
    );

    clkdiv_fanout #(.BANK_W(BANK_W), .INV_UPPER(1'b1)) u_fan_c (
        .active  (act_v[BANK_C]),
        .raw     (raw_v[BANK_C]),
        .inphase (c_inphase),
        .q       (q_c)
    );

    assign q_fb = raw_v[BANK_FB];

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk
    import clkdiv_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              c_inphase,
    input logic [BANK_W-1:0] q_a,
    input logic [BANK_W-1:0] q_b,
    input logic [BANK_W-1:0] q_c,
    input logic              q_fb,
    input cfg_t              cfg
);

    localparam int LOW_W = BANK_W / 2;

    // R1: outputs quiet after a reset edge
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (q_a == '0 && q_b == '0 && q_c == '0 && !q_fb));

    // R8: every divider rises on the first cycle after release
    a_r8_aligned_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> (q_a[0] && q_b[0] && q_c[0] && q_fb));

    // R9: bank C upper half follows the phase control
    a_r9_c_phase: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_c[LOW_W] == (c_inphase ? q_c[0] : ~q_c[0])));

    // R9: outputs inside a bank agree
    a_r9_bank_equal: assert property (@(posedge clk) disable iff (rst)
        (q_a == {BANK_W{q_a[0]}}) && (q_b == {BANK_W{q_b[0]}})
        && (q_c[LOW_W-1:0] == {LOW_W{q_c[0]}}));

    // R10: captured configuration holds while running
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg));

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .c_inphase (c_inphase),
    .q_a       (q_a),
    .q_b       (q_b),
    .q_c       (q_c),
    .q_fb      (q_fb),
    .cfg       (cfg_q)
);

// File: tb/tb_clkdiv_banks.sv
module tb_clkdiv_banks;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_half = 1'b0;
    logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
    logic [2:0] sel_fb = '0;
    logic       c_inphase = 1'b1;
    logic [3:0] q_a, q_b, q_c;
    logic       q_fb;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    clkdiv_banks dut (
        .clk(clk), .rst(rst), .pre_half(pre_half),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .c_inphase(c_inphase),
        .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_fb(q_fb)
    );

    // {pre, sel_a, sel_b, sel_c, sel_fb, inphase}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_00_00_00_000_1,
        11'b0_01_01_01_001_0,
        11'b0_10_10_10_010_1,
        11'b0_11_11_11_011_0,
        11'b1_00_01_10_100_1,
        11'b1_11_10_01_101_0,
        11'b0_10_11_00_110_1,
        11'b1_01_00_11_111_0
    };

    function automatic int ratio_a(logic pre, logic [1:0] s);
        int r;
        case (s) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 12; endcase
        return pre ? 2 * r : r;
    endfunction
    function automatic int ratio_b(logic pre, logic [1:0] s);
        int r;
        case (s) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 10; endcase
        return pre ? 2 * r : r;
    endfunction
    function automatic int ratio_c(logic pre, logic [1:0] s);
        int r;
        case (s) 2'd0: r = 2; 2'd1: r = 4; 2'd2: r = 6; default: r = 8; endcase
        return pre ? 2 * r : r;
    endfunction
    function automatic int ratio_fb(logic pre, logic [2:0] s);
        int r;
        case (s)
            3'd0: r = 4;  3'd1: r = 6;  3'd2: r = 8;  3'd3: r = 10;
            3'd4: r = 8;  3'd5: r = 12; 3'd6: r = 16; default: r = 20;
        endcase
        return pre ? 2 * r : r;
    endfunction
    function automatic logic wave(int ratio, int k);
        return (k % ratio) < (ratio / 2);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [10:0] v);
        pre_half  = v[10];
        sel_a     = v[9:8];
        sel_b     = v[7:6];
        sel_c     = v[5:4];
        sel_fb    = v[3:1];
        c_inphase = v[0];
    endtask

    // Follows all outputs for ncyc cycles from release; k = 0 is the first cycle.
    // Ratios are those given; chg_at >= 0 applies chg_v to the inputs at that cycle.
    task automatic follow(int ra, int rb, int rc, int rf, logic inph, int ncyc,
                          string tag, int chg_at, logic [10:0] chg_v);
        int ea = 0, eb = 0, ec = 0, ef = 0, ep = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (k == chg_at) begin
                apply({chg_v[10:1], inph});
            end
            if (q_a != {4{wave(ra, k)}}) ea++;
            if (q_b != {4{wave(rb, k)}}) eb++;
            if (q_c[1:0] != {2{wave(rc, k)}}) ec++;
            if (q_fb != wave(rf, k)) ef++;
            if (q_c[3:2] != {2{inph ? wave(rc, k) : ~wave(rc, k)}}) ep++;
        end
        chk(ea == 0, {"R2 R7 bank A ", tag}, ea, 0);
        chk(eb == 0, {"R3 R7 bank B ", tag}, eb, 0);
        chk(ec == 0, {"R4 R7 bank C ", tag}, ec, 0);
        chk(ef == 0, {"R5 R7 feedback ", tag}, ef, 0);
        chk(ep == 0, {"R9 bank C upper phase ", tag}, ep, 0);
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        // Watchdog
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state, with bank C upper half set to invert
        apply(11'b0_00_00_00_000_0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(q_a == 4'h0 && q_b == 4'h0 && q_fb == 1'b0, "R1 outputs in reset",
            {q_fb, q_b, q_a}, 0);
        chk(q_c == 4'h0, "R1 bank C in reset (inverted half)", q_c, 0);

        // Table walk; R6 covered by the entries with pre set
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            @(negedge clk);
            rst = 1'b1;
            apply(v);
            repeat (2) @(posedge clk);
            release_rst();
            follow(ratio_a(v[10], v[9:8]), ratio_b(v[10], v[7:6]),
                   ratio_c(v[10], v[5:4]), ratio_fb(v[10], v[3:1]), v[0], 120,
                   v[10] ? "R6 doubled" : "undoubled", -1, 11'b0);
        end

        // R8: first cycle after release, all rise together
        @(negedge clk);
        rst = 1'b1;
        apply(11'b1_11_11_11_111_1);
        repeat (2) @(posedge clk);
        release_rst();
        @(negedge clk);
        chk(q_a[0] && q_b[0] && q_c[0] && q_fb, "R8 aligned first cycle",
            {q_fb, q_c[0], q_b[0], q_a[0]}, 15);

        // R10: selects changed while running are ignored
        @(negedge clk);
        rst = 1'b1;
        apply(11'b0_00_00_00_000_1);
        repeat (2) @(posedge clk);
        release_rst();
        follow(4, 4, 2, 4, 1'b1, 60, "R10 selects moved mid-run", 10,
               11'b1_11_11_11_111_1);

        // R11: single-cycle reset mid-run picks up the new selects, aligned
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(q_a == 4'h0 && q_c == 4'h0 && !q_fb, "R11 R1 outputs low after one reset cycle",
            {q_fb, q_c, q_a}, 0);
        rst = 1'b0;
        @(posedge clk);
        follow(24, 20, 16, 40, 1'b1, 100, "R11 restart", -1, 11'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule